// File: doc/BRIEF.md
# Configurable-trigger interrupt aggregator

This block gathers a vector of interrupt request lines into a single combined interrupt line. Each source has its own trigger type, set by two configuration bits. The trigger can be a rising edge, a falling edge, a high level or a low level. For an edge source a pending bit is latched when the selected edge appears on the registered input, and that bit stays set until software clears it. For a level source the pending bit follows the qualified input level directly.

Software reaches the block through a plain word-addressed register port: address, write enable, write data and a combinational read-data bus. Through this port it can:
- mask or unmask each source;
- read pending bits and clear them by writing ones;
- inject an event on any source by writing its bit in the inject register;
- set the combined line to level or single-cycle pulse, and to active high or active low.

Top module: `irqagg_top`

## Requirements
- R1: After reset, the mask register reads 0, the pending register reads 0, the source-mode and source-polarity registers read all ones, the line-shape and line-polarity registers read 0, and `irq_out` is 0.
- R2: With mode bit 1, a source is edge-triggered: polarity 1 latches its pending bit on a 0-to-1 input transition and polarity 0 latches it on a 1-to-0 transition. The opposite transition latches nothing. The pending bit reads 1 two clock edges after the input changes.
- R3: With mode bit 0, a source is level-sensitive: polarity 1 shows pending while the input is 1, and polarity 0 shows pending while the input is 0.
- R4: A latched pending bit stays set after its input returns to idle. Writing 1 to its bit of the pending register (offset 0x04) clears it. Writing 0 leaves it unchanged.
- R5: In level shape with active-high polarity, `irq_out` is 1 exactly one cycle after some source is both pending and unmasked (mask register, offset 0x00, bit = 1). A pending but masked source leaves `irq_out` at 0.
- R6: Writing 1 to a bit of the inject register (offset 0x18) sets that source's pending bit at the same clock edge. The inject register always reads 0.
- R7: Bit 0 of the line-shape register (offset 0x10) set to 1 selects pulse shape. The line is then active for exactly one cycle when the OR of pending-and-unmasked goes from 0 to 1, one cycle after that rise.
- R8: Bit 0 of the line-polarity register (offset 0x14) set to 1 inverts the combined line, so an idle block drives `irq_out` to 1.
- R9: Register offsets are: mask 0x00, pending 0x04, source mode 0x08, source polarity 0x0C, line shape 0x10, line polarity 0x14, inject 0x18. Writable registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, already synchronous to clk |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out | output | 1 | Combined, shaped interrupt line |

## Verification
The hardest case to reach from the ports is a latched edge event that outlives its cause. The input has to move, return to idle, and leave a pending bit that only a write of one removes. The stimulus first settles each input with the new trigger type in place and clears every pending bit. Only then does it apply the transition under test, so that edges caused by reprogramming cannot pass for real detections. Pulse shape is reached through the inject register, which makes the moment the pending OR rises exact to the cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 8;

  localparam logic [AW-1:0] OFS_MASK  = 8'h00;
  localparam logic [AW-1:0] OFS_PEND  = 8'h04;
  localparam logic [AW-1:0] OFS_SMODE = 8'h08;
  localparam logic [AW-1:0] OFS_SPOL  = 8'h0C;
  localparam logic [AW-1:0] OFS_LSHP  = 8'h10;
  localparam logic [AW-1:0] OFS_LPOL  = 8'h14;
  localparam logic [AW-1:0] OFS_INJ   = 8'h18;

  typedef struct packed {
    logic mask;
    logic pend;
    logic smode;
    logic spol;
    logic lshp;
    logic lpol;
    logic inj;
  } wsel_t;
endpackage

// File: rtl/irqagg_src.sv
module irqagg_src (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic clr_i,
  input  logic inj_i,
  output logic pend_o
);
  logic in_q, in_d, lat_q, lat_n;
  logic hit, lvl;

  always_comb begin
    hit    = mode_i & (pol_i ? (in_q & ~in_d) : (~in_q & in_d));
    lvl    = ~mode_i & ~(in_q ^ pol_i);
    lat_n  = lat_q;
    if (clr_i)         lat_n = 1'b0;
    if (hit || inj_i)  lat_n = 1'b1;
    pend_o = lat_q | lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      in_d  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      in_q  <= in_i;
      in_d  <= in_q;
      lat_q <= lat_n;
    end
  end

  // R4: a latched bit persists unless a clear arrives
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr_i) |=> lat_q);
  // R6: injection sets the latch at the write edge
  a_r6_inject_sets: assert property (@(posedge clk) disable iff (!rst_n)
    inj_i |=> lat_q);
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  rdata_o,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  smode_o,
  output logic [N-1:0]  spol_o,
  output logic          lshp_o,
  output logic          lpol_o,
  output logic [N-1:0]  clr_o,
  output logic [N-1:0]  inj_o
);
  wsel_t        sel;
  logic [N-1:0] mask_q, smode_q, spol_q;
  logic         lshp_q, lpol_q;

  always_comb begin
    sel.mask  = we_i && (addr_i == OFS_MASK);
    sel.pend  = we_i && (addr_i == OFS_PEND);
    sel.smode = we_i && (addr_i == OFS_SMODE);
    sel.spol  = we_i && (addr_i == OFS_SPOL);
    sel.lshp  = we_i && (addr_i == OFS_LSHP);
    sel.lpol  = we_i && (addr_i == OFS_LPOL);
    sel.inj   = we_i && (addr_i == OFS_INJ);
    clr_o = sel.pend ? wdata_i : '0;
    inj_o = sel.inj  ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      smode_q <= '1;
      spol_q  <= '1;
      lshp_q  <= 1'b0;
      lpol_q  <= 1'b0;
    end else begin
      if (sel.mask)  mask_q  <= wdata_i;
      if (sel.smode) smode_q <= wdata_i;
      if (sel.spol)  spol_q  <= wdata_i;
      if (sel.lshp)  lshp_q  <= wdata_i[0];
      if (sel.lpol)  lpol_q  <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_MASK:  rdata_o = mask_q;
      OFS_PEND:  rdata_o = pend_i;
      OFS_SMODE: rdata_o = smode_q;
      OFS_SPOL:  rdata_o = spol_q;
      OFS_LSHP:  rdata_o = {{(N-1){1'b0}}, lshp_q};
      OFS_LPOL:  rdata_o = {{(N-1){1'b0}}, lpol_q};
      default:   rdata_o = '0;
    endcase
  end

  assign mask_o  = mask_q;
  assign smode_o = smode_q;
  assign spol_o  = spol_q;
  assign lshp_o  = lshp_q;
  assign lpol_o  = lpol_q;
endmodule

// File: rtl/irqagg_line.sv
module irqagg_line (
  input  logic clk,
  input  logic rst_n,
  input  logic any_i,
  input  logic shape_i,
  input  logic pol_i,
  output logic irq_o
);
  logic act_q, act_n, any_d;

  always_comb begin
    act_n = shape_i ? (any_i & ~any_d) : any_i;
    irq_o = act_q ^ pol_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      any_d <= 1'b0;
    end else begin
      act_q <= act_n;
      any_d <= any_i;
    end
  end

  // R5: nothing pending and unmasked keeps the line inactive
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !any_i |=> !act_q);
  // R7: in pulse shape the line is active for one cycle only
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_i && $past(shape_i) && $past(act_q)) |-> !act_q);
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_out
);
  logic [NSRC-1:0] mask, smode, spol, clr, inj, pend;
  logic            lshp, lpol;

  irqagg_regs #(.N(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .we_i(reg_we),
    .wdata_i(reg_wdata), .pend_i(pend), .rdata_o(reg_rdata),
    .mask_o(mask), .smode_o(smode), .spol_o(spol), .lshp_o(lshp),
    .lpol_o(lpol), .clr_o(clr), .inj_o(inj)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irqagg_src u_src (
      .clk(clk), .rst_n(rst_n), .in_i(irq_in[g]), .mode_i(smode[g]),
      .pol_i(spol[g]), .clr_i(clr[g]), .inj_i(inj[g]), .pend_o(pend[g])
    );
  end

  irqagg_line u_line (
    .clk(clk), .rst_n(rst_n), .any_i(|(pend & mask)),
    .shape_i(lshp), .pol_i(lpol), .irq_o(irq_out)
  );
endmodule

// File: tb/test_irqagg_top.sv
`timescale 1ns/100ps
module test_irqagg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irqagg_top i_irqagg_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  // {mode, pol, input before, input after, expected pending}
  localparam logic [4:0] VEC [8] = '{
    5'b11_01_1, 5'b11_10_0, 5'b10_10_1, 5'b10_01_0,
    5'b01_01_1, 5'b01_10_0, 5'b00_10_1, 5'b00_01_0
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state, R9 offsets
    rd(8'h00, v); check("R1 mask", v, 32'h0);
    rd(8'h04, v); check("R1 pending", v, 32'h0);
    rd(8'h08, v); check("R1 smode", v, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R1 spol", v, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R1 lshape", v, 32'h0);
    rd(8'h14, v); check("R1 lpol", v, 32'h0);
    check("R1 irq_out", {31'h0, irq_out}, 32'h0);

    // R2/R3 table of trigger encodings on source 0
    for (int i = 0; i < 8; i++) begin
      wr(8'h08, 32'hFFFF_FFFE | {31'h0, VEC[i][4]});
      wr(8'h0C, 32'hFFFF_FFFE | {31'h0, VEC[i][3]});
      irq_in[0] = VEC[i][2];
      idle(3);
      wr(8'h04, 32'h1);
      irq_in[0] = VEC[i][1];
      idle(3);
      rd(8'h04, v);
      check(VEC[i][4] ? "R2 edge trigger" : "R3 level trigger", {31'h0, v[0]}, {31'h0, VEC[i][0]});
    end
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
    irq_in = '0; idle(3); wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R4 clear all", v, 32'h0);

    // R2 latency and R4 hold on source 3
    irq_in[3] = 1'b1;
    idle(1); rd(8'h04, v); check("R2 not yet latched", v, 32'h0);
    idle(1); rd(8'h04, v); check("R2 latched after two edges", v, 32'h8);
    irq_in[3] = 1'b0; idle(3);
    rd(8'h04, v); check("R4 held after input idle", v, 32'h8);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R4 write 0 no effect", v, 32'h8);
    // R5 masking
    idle(2); check("R5 masked stays low", {31'h0, irq_out}, 32'h0);
    wr(8'h00, 32'h8);
    rd(8'h00, v); check("R9 mask readback", v, 32'h8);
    check("R5 one cycle after unmask", {31'h0, irq_out}, 32'h0);
    idle(1); check("R5 unmasked asserts", {31'h0, irq_out}, 32'h1);
    wr(8'h04, 32'h8);
    rd(8'h04, v); check("R4 write 1 clears", v, 32'h0);
    idle(1); check("R5 deasserts after clear", {31'h0, irq_out}, 32'h0);

    // R6 inject, R7 pulse shape
    wr(8'h00, 32'h20);
    wr(8'h10, 32'h1);
    rd(8'h10, v); check("R9 lshape readback", v, 32'h1);
    wr(8'h18, 32'h20);
    rd(8'h04, v); check("R6 inject sets pending", v, 32'h20);
    rd(8'h18, v); check("R6 inject reads zero", v, 32'h0);
    idle(1); check("R7 pulse high", {31'h0, irq_out}, 32'h1);
    idle(1); check("R7 pulse one cycle", {31'h0, irq_out}, 32'h0);
    idle(2); check("R7 pulse stays low", {31'h0, irq_out}, 32'h0);

    // R8 polarity
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h1);
    rd(8'h14, v); check("R9 lpol readback", v, 32'h1);
    idle(1); check("R8 idle active-low high", {31'h0, irq_out}, 32'h1);
    wr(8'h18, 32'h20);
    idle(1); check("R8 active drives low", {31'h0, irq_out}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule